// File: doc/BRIEF.md
# Receive Descriptor Prefetch Controller

This block decides when to pull receive descriptors from a host descriptor ring into a 64-entry on-chip descriptor buffer, and how many to pull in each burst. It compares its own head index with the host tail index to find how many descriptors software has made ready. It also looks at how full the on-chip buffer is and whether higher-priority bus traffic is waiting. From these it either stays quiet or raises one fetch request, which carries a start index, a descriptor count and the matching byte address.

Burst sizes follow cache lines. A normal burst takes everything up to the tail, or up to the end of the ring. When the buffer has less room than the host has ready descriptors, the burst is trimmed so that the next burst begins on a cache-line boundary. This can be a burst that is not a line multiple, so that the controller realigns itself after it has fallen behind. A burst never reads past the tail. It never crosses the ring end either: the head index wraps to zero and the remaining descriptors come in a later burst.

Only one request is outstanding at a time. The request is held until it is granted. The head index moves forward by the granted count only when the completion pulse arrives. The ring length is taken to be a non-zero multiple of the cache-line size, and the buffer occupancy is taken never to exceed the buffer depth.

Top module: `rxd_prefetch_ctrl`

## Requirements
- R1: After reset, req_valid_o is 0 and head_o is 0.
- R2: While occupancy is 0 and at least one descriptor is ready in host memory, a request is raised even if bus_busy_i is 1 and even if fewer than hthresh_i descriptors are ready.
- R3: While occupancy is non-zero, a request is raised only if occupancy is at or below pthresh_i, at least hthresh_i descriptors are ready and bus_busy_i is 0. Otherwise no request appears.
- R4: The ready count is (tail - head) modulo the ring length. When the smaller of the ready count and (ring length - head) fits in the free space (64 - occupancy), the request count equals that smaller value.
- R5: When that smaller value exceeds the free space, the count is the largest value no greater than the free space that makes head + count a multiple of the cache-line size (4 descriptors by default). If no such non-zero value exists, the count equals the free space.
- R6: A request never covers more descriptors than are ready. When tail equals head, no request is raised.
- R7: A request never extends past the last ring index. A burst that reaches the ring end stops there, and the next burst starts at index 0.
- R8: A raised request keeps its index, count and address stable until req_grant_i is seen. No new request is raised between the grant and the completion pulse.
- R9: On done_i, head_o advances by the granted count and wraps to 0 when it reaches the ring length.
- R10: req_addr_o equals ring_base_i + 16 × req_idx_o.
- R11: With the buffer full (occupancy 64), no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_base_i | input | 32 | Byte address of ring entry 0 |
| ring_len_i | input | 10 | Ring length in descriptors |
| tail_i | input | 10 | Host tail index (first entry not yet handed over) |
| pthresh_i | input | 7 | Occupancy at or below which prefetch is allowed |
| hthresh_i | input | 7 | Minimum ready descriptors for a prefetch |
| occ_i | input | 7 | Current on-chip buffer occupancy |
| bus_busy_i | input | 1 | Higher-priority bus traffic pending |
| req_valid_o | output | 1 | Fetch request raised |
| req_idx_o | output | 10 | First ring index of the fetch |
| req_cnt_o | output | 7 | Number of descriptors to fetch |
| req_addr_o | output | 32 | Byte address of the first descriptor |
| req_grant_i | input | 1 | Request accepted by the bus engine |
| done_i | input | 1 | Fetch data fully received |
| head_o | output | 10 | Next ring index to fetch |

## Verification
The hardest case to reach is the trimmed burst that deliberately ends off a line multiple. It needs the head to sit between line boundaries and the buffer to have less room than the host has ready descriptors, both at the same time. The stimulus first issues one-descriptor fetches by moving the tail a single step past the head, which leaves the head misaligned. It then raises occupancy to leave only a few free slots, so that both outcomes of the trim are reached: a burst that lands the next head on a boundary, and the fallback to the whole free space when no boundary is in reach. The ring-end split is reached the same way, by walking the head close to the end and then placing the tail behind it.

// File: rtl/rxd_pf_pkg.sv
// Package: shared types for the receive descriptor prefetch controller.
// Assumes nothing beyond IEEE 1800-2017 packages.
package rxd_pf_pkg;

    // Handshake phases of the single outstanding fetch.
    typedef enum logic [1:0] {
        PF_IDLE = 2'd0,
        PF_REQ  = 2'd1,
        PF_WAIT = 2'd2
    } pf_state_t;

endpackage

// File: rtl/rxd_ring_level.sv
// Ring level: works out how many descriptors the host has ready, how many
// ring entries remain before the wrap point, and how much buffer space is free.
// Assumes head < ring_len, tail < ring_len and occ <= DEPTH.
module rxd_ring_level #(
    parameter int IW    = 10,
    parameter int CW    = 7,
    parameter int DEPTH = 64,
    parameter int WW    = 11
) (
    input  logic [IW-1:0] ring_len,
    input  logic [IW-1:0] head,
    input  logic [IW-1:0] tail,
    input  logic [CW-1:0] occ,
    output logic [WW-1:0] ready_cnt,
    output logic [WW-1:0] to_end,
    output logic [WW-1:0] free_cnt
);

    logic [WW-1:0] len_w, head_w, tail_w, occ_w;

    // Widen all operands to a common width.
    always_comb begin
        len_w  = WW'(ring_len);
        head_w = WW'(head);
        tail_w = WW'(tail);
        occ_w  = WW'(occ);
    end

    // Ready descriptors, measured modulo the ring length.
    always_comb begin
        if (tail_w >= head_w) ready_cnt = tail_w - head_w;
        else                  ready_cnt = len_w - head_w + tail_w;
    end

    // Entries left before the ring wraps to index 0.
    always_comb to_end = len_w - head_w;

    // Free buffer slots, clamped at zero.
    always_comb begin
        if (occ_w >= WW'(DEPTH)) free_cnt = '0;
        else                     free_cnt = WW'(DEPTH) - occ_w;
    end

endmodule

// File: rtl/rxd_fetch_sizer.sv
// Fetch sizer: decides whether a fetch should start now and how many
// descriptors it should cover. Line-oriented trimming applies when
// free space is the binding limit. Assumes LINE is a power of two and the
// ring length is a multiple of LINE.
module rxd_fetch_sizer #(
    parameter int IW    = 10,
    parameter int CW    = 7,
    parameter int DEPTH = 64,
    parameter int LINE  = 4,
    parameter int WW    = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] head,
    input  logic [CW-1:0] occ,
    input  logic [CW-1:0] pthresh,
    input  logic [CW-1:0] hthresh,
    input  logic          bus_busy,
    input  logic [WW-1:0] ready_cnt,
    input  logic [WW-1:0] to_end,
    input  logic [WW-1:0] free_cnt,
    output logic          fire,
    output logic [WW-1:0] cnt
);

    localparam logic [WW-1:0] LINE_MASK = ~WW'(LINE - 1);

    logic [WW-1:0] lim;
    logic [WW-1:0] trim;
    logic [WW-1:0] head_w;
    logic          empty_case;
    logic          pref_case;

    // Smaller of the tail limit and the ring-end limit.
    always_comb begin
        head_w = WW'(head);
        lim    = (ready_cnt < to_end) ? ready_cnt : to_end;
    end

    // Trimmed size used when free space binds; the variant depends on the line size.
    generate
        if (LINE > 1) begin : g_line_trim
            logic [WW-1:0] end_raw;
            logic [WW-1:0] end_al;
            // Pull the end point back to the previous line boundary if one is past the head.
            always_comb begin
                end_raw = head_w + free_cnt;
                end_al  = end_raw & LINE_MASK;
                trim    = (end_al > head_w) ? (end_al - head_w) : free_cnt;
            end
        end else begin : g_no_trim
            // Single-descriptor lines: every size is aligned.
            always_comb trim = free_cnt;
        end
    endgenerate

    // Final count: the full reach if it fits, otherwise the trimmed size.
    always_comb cnt = (lim <= free_cnt) ? lim : trim;

    // Start condition: an empty buffer fetches at once; a prefetch waits for thresholds and an idle bus.
    always_comb begin
        empty_case = (occ == '0);
        pref_case  = (occ <= pthresh) && (ready_cnt >= WW'(hthresh)) && !bus_busy;
        fire       = (ready_cnt != '0) && (free_cnt != '0) && (empty_case || pref_case);
    end

    // R6 R7 R11: a fetch that starts covers at least one entry and stays inside every limit.
    p_cnt_bounds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (cnt != '0) && (cnt <= ready_cnt) && (cnt <= free_cnt) && (cnt <= to_end));

    // R5: a trimmed fetch either ends on a line boundary or takes all free space.
    p_trim_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (cnt < lim) && (cnt != free_cnt)) |-> (((head_w + cnt) & WW'(LINE - 1)) == '0));

endmodule

// File: rtl/rxd_req_fsm.sv
// Request sequencer: holds one fetch request until it is granted, waits for
// completion, then advances the head index with wrap at the ring length.
// Assumes done_i is pulsed only after the grant of the current request.
module rxd_req_fsm
    import rxd_pf_pkg::*;
#(
    parameter int IW      = 10,
    parameter int CW      = 7,
    parameter int AW      = 32,
    parameter int BYTE_SH = 4,
    parameter int WW      = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [WW-1:0] cnt_in,
    input  logic [AW-1:0] ring_base,
    input  logic [IW-1:0] ring_len,
    input  logic          grant,
    input  logic          done,
    output logic          req_valid,
    output logic [IW-1:0] req_idx,
    output logic [CW-1:0] req_cnt,
    output logic [AW-1:0] req_addr,
    output logic [IW-1:0] head
);

    pf_state_t     state;
    logic [WW-1:0] next_head;

    // Candidate head after completion, wrapped at the ring length.
    always_comb begin
        next_head = WW'(head) + WW'(req_cnt);
        if (next_head >= WW'(ring_len)) next_head = '0;
    end

    // Phase sequencing and latching of the request fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PF_IDLE;
            req_idx  <= '0;
            req_cnt  <= '0;
            req_addr <= '0;
            head     <= '0;
        end else begin
            case (state)
                PF_IDLE: begin
                    if (fire) begin
                        state    <= PF_REQ;
                        req_idx  <= head;
                        req_cnt  <= CW'(cnt_in);
                        req_addr <= ring_base + (AW'(head) << BYTE_SH);
                    end
                end
                PF_REQ: begin
                    if (grant) state <= PF_WAIT;
                end
                PF_WAIT: begin
                    if (done) begin
                        state <= PF_IDLE;
                        head  <= IW'(next_head);
                    end
                end
                default: state <= PF_IDLE;
            endcase
        end
    end

    // The request is visible only in the request phase.
    always_comb req_valid = (state == PF_REQ);

    // R8: an ungranted request stays up with unchanged fields.
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !grant) |=> req_valid && $stable(req_idx) && $stable(req_cnt) && $stable(req_addr));

    // R9: the head only moves on a completion pulse.
    p_head_move_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(head));

endmodule

// File: rtl/rxd_prefetch_ctrl.sv
// Receive descriptor prefetch controller (top). Joins the ring level
// calculation, the fetch sizer and the request sequencer. Assumes the ring
// length is a non-zero multiple of LINE and occupancy never exceeds DEPTH.
module rxd_prefetch_ctrl #(
    parameter int IW         = 10,
    parameter int AW         = 32,
    parameter int DEPTH      = 64,
    parameter int LINE       = 4,
    parameter int DESC_BYTES = 16,
    parameter int CW         = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ring_base_i,
    input  logic [IW-1:0] ring_len_i,
    input  logic [IW-1:0] tail_i,
    input  logic [CW-1:0] pthresh_i,
    input  logic [CW-1:0] hthresh_i,
    input  logic [CW-1:0] occ_i,
    input  logic          bus_busy_i,
    output logic          req_valid_o,
    output logic [IW-1:0] req_idx_o,
    output logic [CW-1:0] req_cnt_o,
    output logic [AW-1:0] req_addr_o,
    input  logic          req_grant_i,
    input  logic          done_i,
    output logic [IW-1:0] head_o
);

    localparam int WW      = ((IW + 1) > (CW + 1)) ? (IW + 1) : (CW + 1);
    localparam int BYTE_SH = $clog2(DESC_BYTES);

    logic [WW-1:0] ready_cnt;
    logic [WW-1:0] to_end;
    logic [WW-1:0] free_cnt;
    logic [WW-1:0] size_cnt;
    logic          fire;

    rxd_ring_level #(.IW(IW), .CW(CW), .DEPTH(DEPTH), .WW(WW)) u_level (
        .ring_len  (ring_len_i),
        .head      (head_o),
        .tail      (tail_i),
        .occ       (occ_i),
        .ready_cnt (ready_cnt),
        .to_end    (to_end),
        .free_cnt  (free_cnt)
    );

    rxd_fetch_sizer #(.IW(IW), .CW(CW), .DEPTH(DEPTH), .LINE(LINE), .WW(WW)) u_sizer (
        .clk       (clk),
        .rst_n     (rst_n),
        .head      (head_o),
        .occ       (occ_i),
        .pthresh   (pthresh_i),
        .hthresh   (hthresh_i),
        .bus_busy  (bus_busy_i),
        .ready_cnt (ready_cnt),
        .to_end    (to_end),
        .free_cnt  (free_cnt),
        .fire      (fire),
        .cnt       (size_cnt)
    );

    rxd_req_fsm #(.IW(IW), .CW(CW), .AW(AW), .BYTE_SH(BYTE_SH), .WW(WW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .cnt_in    (size_cnt),
        .ring_base (ring_base_i),
        .ring_len  (ring_len_i),
        .grant     (req_grant_i),
        .done      (done_i),
        .req_valid (req_valid_o),
        .req_idx   (req_idx_o),
        .req_cnt   (req_cnt_o),
        .req_addr  (req_addr_o),
        .head      (head_o)
    );

    // R3: a request raised with a non-empty buffer never starts while the bus was busy.
    p_defer_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid_o) |-> (($past(occ_i) == '0) || !$past(bus_busy_i)));

    // R7: a request never runs past the last ring index.
    p_ring_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> ((WW'(req_idx_o) + WW'(req_cnt_o)) <= WW'(ring_len_i)));

    // R8: a request only drops after a grant.
    p_drop_on_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_valid_o) |-> $past(req_grant_i));

    // R10: the address matches the start index.
    p_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (req_addr_o == ring_base_i + (AW'(req_idx_o) << BYTE_SH)));

endmodule

// File: tb/rxd_prefetch_ctrl_bench.sv
// Directed bench for the receive descriptor prefetch controller.
module rxd_prefetch_ctrl_bench;

    localparam int IW = 10;
    localparam int AW = 32;
    localparam int CW = 7;
    localparam logic [AW-1:0] BASE = 32'h1000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ring_base_i = BASE;
    logic [IW-1:0] ring_len_i = 10'd128;
    logic [IW-1:0] tail_i = '0;
    logic [CW-1:0] pthresh_i = '0;
    logic [CW-1:0] hthresh_i = '0;
    logic [CW-1:0] occ_i = 7'd64;
    logic          bus_busy_i = 1'b0;
    logic          req_valid_o;
    logic [IW-1:0] req_idx_o;
    logic [CW-1:0] req_cnt_o;
    logic [AW-1:0] req_addr_o;
    logic          req_grant_i = 1'b0;
    logic          done_i = 1'b0;
    logic [IW-1:0] head_o;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    rxd_prefetch_ctrl u_rxd_prefetch_ctrl (
        .clk(clk), .rst_n(rst_n), .ring_base_i(ring_base_i), .ring_len_i(ring_len_i),
        .tail_i(tail_i), .pthresh_i(pthresh_i), .hthresh_i(hthresh_i), .occ_i(occ_i),
        .bus_busy_i(bus_busy_i), .req_valid_o(req_valid_o), .req_idx_o(req_idx_o),
        .req_cnt_o(req_cnt_o), .req_addr_o(req_addr_o), .req_grant_i(req_grant_i),
        .done_i(done_i), .head_o(head_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Wait for a request, check it, grant it, park the buffer as full, complete it.
    task automatic do_fetch(input string req, input int idx, input int cnt);
        int waited = 0;
        while (!req_valid_o && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        check({req, " valid"}, 32'(req_valid_o), 32'd1);
        check({req, " idx"}, 32'(req_idx_o), 32'(idx));
        check({req, " cnt"}, 32'(req_cnt_o), 32'(cnt));
        check("R10 addr", req_addr_o, BASE + 32'(idx * 16));
        req_grant_i = 1'b1;
        @(negedge clk);
        req_grant_i = 1'b0;
        occ_i = 7'd64;
        @(negedge clk);
        done_i = 1'b1;
        @(negedge clk);
        done_i = 1'b0;
        check("R9 head", 32'(head_o), 32'((idx + cnt) % 128));
    endtask

    // No request may appear for several cycles.
    task automatic expect_quiet(input string req);
        logic seen = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (req_valid_o) seen = 1'b1;
        end
        check(req, 32'(seen), 32'd0);
    endtask

    task automatic t_reset();
        check("R1 valid", 32'(req_valid_o), 32'd0);
        check("R1 head", 32'(head_o), 32'd0);
    endtask

    // Empty buffer: fetch despite busy bus and low ready count; hold until grant.
    task automatic t_empty_fetch();
        tail_i = 10'd5; hthresh_i = 7'd8; bus_busy_i = 1'b1; occ_i = 7'd0;
        repeat (3) @(negedge clk);
        check("R2 valid", 32'(req_valid_o), 32'd1);
        check("R8 held idx", 32'(req_idx_o), 32'd0);
        check("R2 cnt", 32'(req_cnt_o), 32'd5);
        req_grant_i = 1'b1;
        @(negedge clk);
        req_grant_i = 1'b0;
        expect_quiet("R8 no second request before done");
        done_i = 1'b1;
        occ_i = 7'd64;
        @(negedge clk);
        done_i = 1'b0;
        check("R9 head after first", 32'(head_o), 32'd5);
        bus_busy_i = 1'b0;
    endtask

    // Prefetch gating by threshold, host count and bus activity.
    task automatic t_prefetch_gate();
        tail_i = 10'd40; pthresh_i = 7'd8; hthresh_i = 7'd16; occ_i = 7'd10;
        expect_quiet("R3 above pthresh");
        occ_i = 7'd8; hthresh_i = 7'd40;
        expect_quiet("R3 below hthresh");
        hthresh_i = 7'd16; bus_busy_i = 1'b1;
        expect_quiet("R3 busy defers");
        bus_busy_i = 1'b0;
        do_fetch("R4 reach to tail", 5, 35);
    endtask

    // Free space binds: aligned trim, non-aligned trim, fallback to free space.
    task automatic t_free_limit();
        pthresh_i = 7'd63; hthresh_i = 7'd1;
        tail_i = 10'd100; occ_i = 7'd50;
        do_fetch("R5 aligned trim", 40, 12);
        tail_i = 10'd53; occ_i = 7'd0;
        do_fetch("R6 stop at tail", 52, 1);
        tail_i = 10'd100; occ_i = 7'd58;
        do_fetch("R5 realign trim", 53, 3);
        tail_i = 10'd57; occ_i = 7'd0;
        do_fetch("R6 single", 56, 1);
        tail_i = 10'd100; occ_i = 7'd62;
        do_fetch("R5 fallback free", 57, 2);
    endtask

    task automatic t_full();
        occ_i = 7'd64;
        expect_quiet("R11 full buffer");
    endtask

    // Ring-end split and restart from index 0, then tail equal to head.
    task automatic t_wrap();
        tail_i = 10'd120; occ_i = 7'd0;
        do_fetch("R4 long run", 59, 61);
        tail_i = 10'd10; occ_i = 7'd0;
        do_fetch("R7 split at ring end", 120, 8);
        check("R7 head wrapped", 32'(head_o), 32'd0);
        occ_i = 7'd0;
        do_fetch("R7 restart at zero", 0, 10);
        occ_i = 7'd0;
        expect_quiet("R6 tail equals head");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty_fetch();
        t_prefetch_gate();
        t_free_limit();
        t_full();
        t_wrap();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule